// File: doc/BRIEF.md
# Serial Frame Scheduler with Control Frames

This block sets the frame-sync timing of a synchronous serial codec port that carries two kinds of 16-bit frame on the same wires. Data frames repeat every 256 bit clocks. Control frames sit between data frames, at either one half or one quarter of the data-frame interval. The block runs on the bit clock itself. A host reads and writes an 8-bit configuration register and moves serial words through `sdin_i` and `sdout_o`. Each data frame shifts the converter's receive word out on `sdout_o`. At the same time it collects the host's transmit word from `sdin_i`.

Two mode bits control the control frames. In automatic mode a control frame follows every data frame, and all 16 incoming data bits form the transmit word. In request mode the last bit of an incoming data frame (bit 0) is a request flag. A control frame is then issued in that same interval only when the flag is set. A digital loopback bit routes the transmit word back into the receive path, so the next data frame returns it on `sdout_o`.

Top module: `frame_sched`

## Requirements
- R1: After reset the configuration register reads 0x00. `tx_valid_o` and `ctrl_valid_o` are low. `fsync_o` is high in reset, and the first data frame begins in the first bit clock after reset is released.
- R2: A write stores all 8 bits, and they read back on `cfg_rdata` from the cycle after the write. Bit 0 selects automatic mode and bit 1 selects the quarter position. Bit 6 enables digital loopback. Bits 7, 5, 4, 3 and 2 are stored only and have no other effect.
- R3: A data-frame sync pulse lasts one bit clock, with `fsync_ctrl_o` low. The data-frame syncs repeat every 256 bit clocks. The 16 data bits occupy the 16 bit clocks after the sync, MSB first, on both `sdin_i` and `sdout_o`.
- R4: One bit clock after the last data bit, `tx_valid_o` pulses for one cycle. At the same moment `tx_word_o` presents the collected word, which keeps all 16 bits in automatic mode.
- R5: In request mode, bit 0 of the incoming data frame is a request flag and reads as 0 in `tx_word_o`. A control frame occurs in that interval if and only if the flag was 1.
- R6: In automatic mode, a control frame follows every data frame whatever the value of bit 0.
- R7: A control frame's sync pulse has `fsync_ctrl_o` high together with `fsync_o`. It comes 128 bit clocks after the data-frame sync when bit 1 is 0, and 64 bit clocks after it when bit 1 is 1.
- R8: The 16 bits after a control sync are collected MSB first into `ctrl_word_o`, and `ctrl_valid_o` pulses one bit clock after the last of them.
- R9: With loopback on at the start of an interval, `sdout_o` carries the transmit word collected in the previous interval instead of `rx_word_i`. With loopback off, it carries the `rx_word_i` value present at the data-frame sync.
- R10: Changes to the mode and position bits take effect only at the next data-frame sync. A control frame already under way always completes, and its `ctrl_valid_o` pulse still arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Configuration read value |
| rx_word_i | input | 16 | Receive word from the converter, taken at each data-frame sync |
| sdin_i | input | 1 | Serial data from host |
| sdout_o | output | 1 | Serial data to host |
| fsync_o | output | 1 | Frame sync, high one bit clock before each frame |
| fsync_ctrl_o | output | 1 | Marks a frame sync as a control-frame sync |
| tx_word_o | output | 16 | Last transmit word collected from a data frame |
| tx_valid_o | output | 1 | One-cycle pulse when `tx_word_o` updates |
| ctrl_word_o | output | 16 | Last word collected from a control frame |
| ctrl_valid_o | output | 1 | One-cycle pulse when `ctrl_word_o` updates |

## Verification
The bench measures the distance from each data sync to the control sync. A design that decodes the position bit wrongly, or applies it at once instead of at the boundary, shows the control frame at the wrong bit clock. Request mode is exercised with bit 0 both clear and set, and automatic mode with bit 0 clear. A swapped mode sense would add or lose a control frame, or leak the flag into `tx_word_o`. Loopback is checked against the word collected one interval earlier, which exposes an off-by-one-interval source. A configuration change made in the middle of a control frame must still let `ctrl_valid_o` arrive at its normal time.

// File: rtl/frame_sched_pkg.sv
package frame_sched_pkg;

    typedef struct packed {
        logic tmode;
        logic loop_dig;
        logic loop_ana;
        logic loop_int;
        logic ckout;
        logic rxbias;
        logic ctrl_quarter;
        logic auto_ctrl;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/sfs_cfg_reg.sv
module sfs_cfg_reg
    import frame_sched_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg_o
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) cfg_d = cfg_t'(wdata);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/sfs_timer.sv
module sfs_timer #(
    parameter int PERIOD = 256,
    parameter int POS_W  = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             quarter_i,
    input  logic             auto_i,
    output logic [POS_W-1:0] pos_o,
    output logic             boundary_o,
    output logic             act_auto_o,
    output logic [POS_W-1:0] ctrl_ofs_o
);
    localparam logic [POS_W-1:0] LAST    = POS_W'(PERIOD - 1);
    localparam logic [POS_W-1:0] QUARTER = POS_W'(PERIOD / 4);
    localparam logic [POS_W-1:0] HALF    = POS_W'(PERIOD / 2);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             quarter;
        logic             auto_m;
    } tmr_t;

    tmr_t st_d, st_q;
    logic at_end;

    always_comb begin
        at_end = (st_q.pos == LAST);
        st_d   = st_q;
        if (at_end) begin
            st_d.pos     = '0;
            st_d.quarter = quarter_i;
            st_d.auto_m  = auto_i;
        end else begin
            st_d.pos = st_q.pos + POS_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pos     <= LAST;
            st_q.quarter <= 1'b0;
            st_q.auto_m  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_o      = st_q.pos;
    assign boundary_o = at_end;
    assign act_auto_o = st_q.auto_m;
    assign ctrl_ofs_o = st_q.quarter ? QUARTER : HALF;
endmodule

// File: rtl/sfs_deser.sv
module sfs_deser #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         last_i,
    input  logic         keep_lsb,
    input  logic         din,
    output logic [W-1:0] word_o,
    output logic         valid_o
);
    typedef struct packed {
        logic [W-1:0] sh;
        logic [W-1:0] word;
        logic         valid;
    } ds_t;

    ds_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (shift_en) begin
            st_d.sh = {st_q.sh[W-2:0], din};
            if (last_i) begin
                st_d.word  = {st_q.sh[W-2:0], keep_lsb & din};
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o  = st_q.word;
    assign valid_o = st_q.valid;
endmodule

// File: rtl/frame_sched.sv
module frame_sched
    import frame_sched_pkg::*;
#(
    parameter int PERIOD     = 256,
    parameter int FRAME_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [7:0]            cfg_wdata,
    output logic [7:0]            cfg_rdata,
    input  logic [FRAME_BITS-1:0] rx_word_i,
    input  logic                  sdin_i,
    output logic                  sdout_o,
    output logic                  fsync_o,
    output logic                  fsync_ctrl_o,
    output logic [FRAME_BITS-1:0] tx_word_o,
    output logic                  tx_valid_o,
    output logic [FRAME_BITS-1:0] ctrl_word_o,
    output logic                  ctrl_valid_o
);
    localparam int POS_W = $clog2(PERIOD);
    localparam logic [POS_W-1:0] DATA_LAST = POS_W'(FRAME_BITS - 1);
    localparam logic [POS_W-1:0] NBITS     = POS_W'(FRAME_BITS);

    cfg_t             cfg;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] ctrl_ofs;
    logic             boundary;
    logic             act_auto;
    logic             data_bit, data_last, ctrl_start, ctrl_last;

    typedef struct packed {
        logic [FRAME_BITS-1:0] out_sh;
        logic                  pend;
        logic                  ctrl_act;
    } top_t;

    top_t st_d, st_q;

    sfs_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_o (cfg)
    );

    sfs_timer #(.PERIOD(PERIOD)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .quarter_i  (cfg.ctrl_quarter),
        .auto_i     (cfg.auto_ctrl),
        .pos_o      (pos),
        .boundary_o (boundary),
        .act_auto_o (act_auto),
        .ctrl_ofs_o (ctrl_ofs)
    );

    sfs_deser #(.W(FRAME_BITS)) u_data_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (data_bit),
        .last_i   (data_last),
        .keep_lsb (act_auto),
        .din      (sdin_i),
        .word_o   (tx_word_o),
        .valid_o  (tx_valid_o)
    );

    sfs_deser #(.W(FRAME_BITS)) u_ctrl_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (st_q.ctrl_act),
        .last_i   (ctrl_last),
        .keep_lsb (1'b1),
        .din      (sdin_i),
        .word_o   (ctrl_word_o),
        .valid_o  (ctrl_valid_o)
    );

    always_comb begin
        data_bit   = (pos < NBITS);
        data_last  = (pos == DATA_LAST);
        ctrl_start = st_q.pend && (pos == ctrl_ofs - POS_W'(1));
        ctrl_last  = st_q.ctrl_act && (pos == ctrl_ofs + DATA_LAST);

        st_d = st_q;
        if (boundary)
            st_d.out_sh = cfg.loop_dig ? tx_word_o : rx_word_i;
        else if (data_bit)
            st_d.out_sh = {st_q.out_sh[FRAME_BITS-2:0], 1'b0};

        if (data_last && (act_auto || sdin_i)) st_d.pend = 1'b1;
        else if (ctrl_start)                   st_d.pend = 1'b0;

        if (ctrl_start)     st_d.ctrl_act = 1'b1;
        else if (ctrl_last) st_d.ctrl_act = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_rdata    = cfg;
    assign fsync_o      = boundary || ctrl_start;
    assign fsync_ctrl_o = ctrl_start;
    assign sdout_o      = data_bit & st_q.out_sh[FRAME_BITS-1];
endmodule

// File: rtl/frame_sched_chk.sv
module frame_sched_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         fsync_o,
    input logic         fsync_ctrl_o,
    input logic         tx_valid_o,
    input logic [W-1:0] tx_word_o,
    input logic         ctrl_valid_o,
    input logic         cfg_we,
    input logic [7:0]   cfg_wdata,
    input logic [7:0]   cfg_rdata,
    input logic         act_auto
);
    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata == $past(cfg_wdata)); // R2
    AST_FSYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_o |=> !fsync_o); // R3
    AST_TXV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o |=> !tx_valid_o); // R4
    AST_REQ_BIT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !act_auto) |-> !tx_word_o[0]); // R5
    AST_CTRL_MARK_WITH_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_ctrl_o |-> fsync_o); // R7
    AST_CTRLV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_valid_o |=> !ctrl_valid_o); // R8
endmodule

bind frame_sched frame_sched_chk #(.W(FRAME_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fsync_o      (fsync_o),
    .fsync_ctrl_o (fsync_ctrl_o),
    .tx_valid_o   (tx_valid_o),
    .tx_word_o    (tx_word_o),
    .ctrl_valid_o (ctrl_valid_o),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .act_auto     (act_auto)
);

// File: tb/frame_sched_test.sv
`timescale 1ns/1ps
module frame_sched_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [15:0] rx_word_i = '0;
    logic        sdin_i = 1'b0;
    logic        sdout_o, fsync_o, fsync_ctrl_o, tx_valid_o, ctrl_valid_o;
    logic [15:0] tx_word_o, ctrl_word_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    frame_sched uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .rx_word_i(rx_word_i), .sdin_i(sdin_i),
        .sdout_o(sdout_o), .fsync_o(fsync_o), .fsync_ctrl_o(fsync_ctrl_o),
        .tx_word_o(tx_word_o), .tx_valid_o(tx_valid_o),
        .ctrl_word_o(ctrl_word_o), .ctrl_valid_o(ctrl_valid_o)
    );

    // {cfg, data word, rx word, control word}
    localparam logic [55:0] VEC [8] = '{
        {8'h00, 16'hA5A4, 16'h1234, 16'h0F0F},
        {8'h00, 16'h3C3D, 16'h4321, 16'h8001},
        {8'h02, 16'h0001, 16'h7E7E, 16'h1357},
        {8'h01, 16'hBEEF, 16'h00FF, 16'h2468},
        {8'h03, 16'h1230, 16'hFF00, 16'h9999},
        {8'h41, 16'h5555, 16'hDEAD, 16'h6666},
        {8'h40, 16'h0F0F, 16'hBEEF, 16'h7777},
        {8'hFC, 16'h0002, 16'hCAFE, 16'h4242}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
        check(cfg_rdata == v, "R2 readback", {24'h0, cfg_rdata}, {24'h0, v});
    endtask

    task automatic wait_data_sync();
        for (int g = 0; g < 600; g++) begin
            @(negedge clk);
            if (fsync_o && !fsync_ctrl_o) return;
        end
        check(1'b0, "R3 data sync missing", 0, 1);
    endtask

    logic [15:0] prev_tx = 16'h0000;

    task automatic run_row(input logic [55:0] v);
        logic [7:0]  c;
        logic [15:0] w, rx, cw, txe, sdo_exp, got;
        bit          auto_m, quarter, lb, exp_ctrl, seen;
        int          gap, ofs;
        c = v[55:48]; w = v[47:32]; rx = v[31:16]; cw = v[15:0];
        auto_m = c[0]; quarter = c[1]; lb = c[6];
        txe = auto_m ? w : {w[15:1], 1'b0};
        sdo_exp = lb ? prev_tx : rx;
        exp_ctrl = auto_m || w[0];
        ofs = quarter ? 64 : 128;
        write_cfg(c);
        rx_word_i = rx;
        wait_data_sync();
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk);
            got[i] = sdout_o;
            sdin_i = w[i];
        end
        @(negedge clk); sdin_i = 1'b0;
        check(tx_valid_o && tx_word_o == txe, "R4/R5 tx word", {15'h0, tx_valid_o, tx_word_o}, {16'h1, txe});
        check(got == sdo_exp, lb ? "R9 loopback sdout" : "R3 sdout", {16'h0, got}, {16'h0, sdo_exp});
        seen = 1'b0; gap = 0;
        for (int k = 18; k <= 240; k++) begin
            @(negedge clk);
            if (fsync_o) begin seen = 1'b1; gap = k; break; end
        end
        check(seen == exp_ctrl, auto_m ? "R6 control frame presence" : "R5 control frame presence",
              {31'h0, seen}, {31'h0, exp_ctrl});
        if (seen) begin
            check(fsync_ctrl_o && gap == ofs, "R7 control sync position", gap, ofs);
            for (int i = 15; i >= 0; i--) begin
                @(negedge clk);
                sdin_i = cw[i];
            end
            @(negedge clk); sdin_i = 1'b0;
            check(ctrl_valid_o && ctrl_word_o == cw, "R8 control word",
                  {15'h0, ctrl_valid_o, ctrl_word_o}, {16'h1, cw});
        end
        prev_tx = txe;
    endtask

    initial begin
        #1_000_000;
        fails++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int gap, cv_at, per;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cfg_rdata == 8'h00, "R1 cfg reset", {24'h0, cfg_rdata}, 0);
        check(!tx_valid_o && !ctrl_valid_o, "R1 valids low", {30'h0, tx_valid_o, ctrl_valid_o}, 0);
        check(fsync_o == 1'b1, "R1 sync in reset", {31'h0, fsync_o}, 1);
        rst_n = 1'b1;

        // R3: period between data syncs
        wait_data_sync();
        per = 0;
        for (int k = 1; k <= 300; k++) begin
            @(negedge clk);
            if (fsync_o && !fsync_ctrl_o) begin per = k; break; end
        end
        check(per == 256, "R3 data period", per, 256);

        foreach (VEC[r]) run_row(VEC[r]);

        // R10: mid-interval change waits for the boundary
        write_cfg(8'h01);
        wait_data_sync();
        gap = 0; cv_at = 0;
        for (int k = 1; k <= 240; k++) begin
            @(negedge clk);
            if (k == 20) begin cfg_we = 1'b1; cfg_wdata = 8'h03; end
            if (k == 21) cfg_we = 1'b0;
            if (fsync_o && gap == 0) gap = k;
            if (ctrl_valid_o) cv_at = k;
        end
        check(gap == 128, "R10 position held this interval", gap, 128);
        check(cv_at == 145, "R10 control word timing", cv_at, 145);
        wait_data_sync();
        gap = 0; cv_at = 0;
        for (int k = 1; k <= 240; k++) begin
            @(negedge clk);
            if (k == 70) begin cfg_we = 1'b1; cfg_wdata = 8'h00; end
            if (k == 71) cfg_we = 1'b0;
            if (fsync_o && gap == 0) gap = k;
            if (ctrl_valid_o) cv_at = k;
        end
        check(gap == 64, "R10 new position after boundary", gap, 64);
        check(cv_at == 81, "R10 control frame not cut short", cv_at, 81);

        // R1: reset in the middle of operation
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check(cfg_rdata == 8'h00 && !tx_valid_o && !ctrl_valid_o, "R1 reset mid-run",
              {22'h0, cfg_rdata, tx_valid_o, ctrl_valid_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(fsync_o == 1'b0, "R1 first frame starts after release", {31'h0, fsync_o}, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule